// File: doc/BRIEF.md
# Packet Device Interrupt Status and Control Register

This block holds the interrupt state of a byte-streaming packet device. Two hardware events, "a transmit has finished" and "a received packet is now available", are latched as sticky status bits that the host retires by writing 1 to them. A single level-sensitive interrupt line is raised while any of them is pending.

A self-test path lets software raise the interrupt on purpose. Writing 1 to the top bit raises a test flag and a separate test-pending condition. The flag is visible in the top bit of the register and drops after one read. The pending condition keeps the interrupt line high until the host writes an all-zero value to the register.

The block also holds back receive traffic. A packet offered by the receive side is only taken while the receive status bit is clear, so the host must acknowledge one packet before it sees the next.

Top module: `pkt_irq_ctrl`

## Requirements
- R1: After reset the register reads 0x0000_0000, the interrupt output is low, and the receive take output follows the receive offer input.
- R2: A transmit-done pulse sets bit 0 on the next clock edge. The bit stays set until the host clears it.
- R3: A host write with bit 0 or bit 1 at 1 clears that bit on the next edge. A write with that bit at 0 leaves it unchanged.
- R4: When a hardware set event and a host clear of the same bit fall on the same cycle, the bit stays set.
- R5: The receive take output equals receive offer AND NOT bit 1. A take sets bit 1 on the next edge.
- R6: A write with bit 31 at 1 sets bit 31 of the read value and raises the interrupt on the next edge.
- R7: A read strobe clears bit 31 on the next edge. The interrupt raised by the test remains high. A write setting bit 31 in the same cycle as a read wins.
- R8: Only a write of the value 0x0000_0000 retires the test interrupt. A nonzero write with bit 31 at 0 does not retire it.
- R9: The interrupt output is high exactly when bit 0, bit 1 or the test-pending condition is set.
- R10: Bits 30 down to 2 always read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_done_i | input | 1 | One-cycle pulse: a transmit has finished |
| rx_offer_i | input | 1 | Receive side has a packet ready to hand over |
| rx_take_o | output | 1 | Packet is taken this cycle |
| reg_wr_i | input | 1 | Host write strobe |
| reg_rd_i | input | 1 | Host read strobe (triggers the read side effect) |
| reg_wdata_i | input | 32 | Host write data |
| reg_rdata_o | output | 32 | Current register value |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
The hardest state to reach is the one where the test flag has already been consumed by a read but the test interrupt is still pending. In that state the interrupt line is high while every visible status bit is 0. The stimulus reaches it by writing the test bit, reading once, and then issuing a nonzero write without bit 31 before the all-zero write. Set-versus-clear collisions are forced by pulsing transmit-done in the same cycle as the clearing write. The same is done for a read coinciding with a test-bit write. A pseudo-random phase then mixes every input against a behavioural model.

// File: rtl/pkt_irq_pkg.sv
// Package: register width and bit positions shared by the interrupt block.
// Assumes a single 32-bit register with the fixed bit placement below,
// which host software decodes.
package pkt_irq_pkg;
    localparam int REG_W   = 32;
    localparam int TX_BIT  = 0;
    localparam int RX_BIT  = 1;
    localparam int TST_BIT = REG_W - 1;
endpackage

// File: rtl/pkt_irq_sticky.sv
// Module: one sticky status bit.
// A hardware set has priority over a host clear arriving in the same cycle.
// Assumes set_i and clr_i are single-cycle qualified strobes.
module pkt_irq_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    // Hold the bit: set wins, otherwise clear, otherwise keep.
    always_ff @(posedge clk) begin
        if (!rst_n)     q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end
endmodule

// File: rtl/pkt_irq_test.sv
// Module: self-test state.
// The visible flag is set by a write of the test bit and dropped by a read.
// The pending condition is set by the same write and dropped only by an
// all-zero write.
// Assumes at most one write per cycle.
module pkt_irq_test (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic rd_i,
    input  logic zero_wr_i,
    output logic flag_o,
    output logic pend_o
);
    // Visible flag: arming beats a simultaneous read.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (arm_i) flag_o <= 1'b1;
        else if (rd_i)  flag_o <= 1'b0;
    end

    // Pending interrupt: retired only by an all-zero write.
    always_ff @(posedge clk) begin
        if (!rst_n)         pend_o <= 1'b0;
        else if (arm_i)     pend_o <= 1'b1;
        else if (zero_wr_i) pend_o <= 1'b0;
    end
endmodule

// File: rtl/pkt_irq_ctrl.sv
// Module: interrupt status and control register of the packet device.
// It latches transmit-done and receive-available status, gates receive
// hand-over while receive status is pending, and drives one level
// interrupt.
// Assumes the host holds read data stable from reg_rdata_o and uses
// reg_rd_i only to signal that a read took place.
module pkt_irq_ctrl
    import pkt_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_done_i,
    input  logic             rx_offer_i,
    output logic             rx_take_o,
    input  logic             reg_wr_i,
    input  logic             reg_rd_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    output logic [REG_W-1:0] reg_rdata_o,
    output logic             irq_o
);
    localparam int NSTAT = 2;

    logic [NSTAT-1:0] stat_q;
    logic [NSTAT-1:0] stat_set;
    logic [NSTAT-1:0] stat_clr;
    logic             tst_flag;
    logic             tst_pend;
    logic             zero_wr;

    // Receive gate: hand over a packet only while receive status is clear.
    always_comb rx_take_o = rx_offer_i & ~stat_q[RX_BIT];

    // Hardware set sources per status bit.
    always_comb begin
        stat_set         = '0;
        stat_set[TX_BIT] = tx_done_i;
        stat_set[RX_BIT] = rx_take_o;
    end

    // Detect the all-zero write that retires the test interrupt.
    always_comb zero_wr = reg_wr_i & (reg_wdata_i == '0);

    // One sticky bit per status source, cleared by write-one.
    for (genvar i = 0; i < NSTAT; i++) begin : g_stat
        always_comb stat_clr[i] = reg_wr_i & reg_wdata_i[i];
        pkt_irq_sticky u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (stat_set[i]),
            .clr_i (stat_clr[i]),
            .q_o   (stat_q[i])
        );
    end

    pkt_irq_test u_test (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (reg_wr_i & reg_wdata_i[TST_BIT]),
        .rd_i      (reg_rd_i),
        .zero_wr_i (zero_wr),
        .flag_o    (tst_flag),
        .pend_o    (tst_pend)
    );

    // Read image: status in the low bits, test flag on top, rest zero.
    always_comb begin
        reg_rdata_o            = '0;
        reg_rdata_o[NSTAT-1:0] = stat_q;
        reg_rdata_o[TST_BIT]   = tst_flag;
    end

    // Level interrupt from any pending source.
    always_comb irq_o = (|stat_q) | tst_pend;
endmodule

// File: rtl/pkt_irq_ctrl_chk.sv
// Checker: temporal properties of the interrupt register, observed at the
// ports of pkt_irq_ctrl.
module pkt_irq_ctrl_chk
    import pkt_irq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             tx_done_i,
    input logic             rx_offer_i,
    input logic             rx_take_o,
    input logic             reg_wr_i,
    input logic             reg_rd_i,
    input logic [REG_W-1:0] reg_wdata_i,
    input logic [REG_W-1:0] reg_rdata_o,
    input logic             irq_o
);
    assert_tx_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done_i |=> reg_rdata_o[TX_BIT]);

    assert_w1c_tx_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_wdata_i[TX_BIT] && !tx_done_i) |=> !reg_rdata_o[TX_BIT]);

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_wdata_i[TX_BIT] && tx_done_i) |=> reg_rdata_o[TX_BIT]);

    assert_rx_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_take_o |-> (rx_offer_i && !reg_rdata_o[RX_BIT]));

    assert_rx_take_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_take_o |=> reg_rdata_o[RX_BIT]);

    assert_test_arm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_wdata_i[TST_BIT]) |=> (irq_o && reg_rdata_o[TST_BIT]));

    assert_test_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_i && !(reg_wr_i && reg_wdata_i[TST_BIT])) |=> !reg_rdata_o[TST_BIT]);

    assert_zero_write_retires_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_wdata_i == '0 && !tx_done_i && !rx_take_o
         && !reg_rdata_o[TX_BIT] && !reg_rdata_o[RX_BIT]) |=> !irq_o);

    assert_irq_covers_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata_o[TX_BIT] || reg_rdata_o[RX_BIT]) |-> irq_o);

    assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata_o[TST_BIT-1:RX_BIT+1] == '0);
endmodule

bind pkt_irq_ctrl pkt_irq_ctrl_chk u_chk (.*);

// File: tb/tb_pkt_irq_ctrl.sv
module tb_pkt_irq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_done_i = 1'b0;
    logic        rx_offer_i = 1'b0;
    logic        rx_take_o;
    logic        reg_wr_i = 1'b0;
    logic        reg_rd_i = 1'b0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic        irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // Behavioural model state
    bit m_tx, m_rx, m_flag, m_pend;

    pkt_irq_ctrl dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_rdata();
        return {m_flag, 29'd0, m_rx, m_tx};
    endfunction

    // One clock: drive at negedge, check gate, update model at edge, compare.
    task automatic step(input bit tx, input bit offer, input bit wr, input bit rd,
                        input logic [31:0] wd);
        bit take;
        @(negedge clk);
        tx_done_i = tx; rx_offer_i = offer; reg_wr_i = wr; reg_rd_i = rd; reg_wdata_i = wd;
        #1;
        take = offer && !m_rx;
        chk("R5 take gate", {31'd0, rx_take_o}, {31'd0, take});
        @(posedge clk);
        m_tx   = tx | (m_tx & !(wr & wd[0]));
        m_rx   = take | (m_rx & !(wr & wd[1]));
        m_flag = (wr & wd[31]) | (m_flag & !rd);
        m_pend = (wr & wd[31]) | (m_pend & !(wr && wd == 0));
        #1;
        chk("R9 model rdata", reg_rdata_o, m_rdata());
        chk("R9 model irq", {31'd0, irq_o}, {31'd0, (m_tx | m_rx | m_pend)});
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset rdata", reg_rdata_o, 32'h0);
        chk("R1 reset irq", {31'd0, irq_o}, 32'h0);
        rx_offer_i = 1'b1; #1;
        chk("R1 take follows offer", {31'd0, rx_take_o}, 32'h1);
        rx_offer_i = 1'b0;

        // R2: transmit done sets bit 0 and it sticks
        step(1, 0, 0, 0, 32'h0);
        chk("R2 tx set", reg_rdata_o, 32'h1);
        idle();
        chk("R2 tx sticky", reg_rdata_o, 32'h1);
        // R3: clear of other bit leaves it, W1C clears it
        step(0, 0, 1, 0, 32'h2);
        chk("R3 no clear by 0", reg_rdata_o, 32'h1);
        step(0, 0, 1, 0, 32'h1);
        chk("R3 w1c", reg_rdata_o, 32'h0);
        // R4: set wins over clear
        step(1, 0, 1, 0, 32'h1);
        chk("R4 set wins", reg_rdata_o, 32'h1);
        step(0, 0, 1, 0, 32'h1);

        // R5: receive gating
        step(0, 1, 0, 0, 32'h0);
        chk("R5 rx set", reg_rdata_o, 32'h2);
        step(0, 1, 0, 0, 32'h0);
        chk("R5 held off", {31'd0, rx_take_o}, 32'h0);
        step(0, 1, 1, 0, 32'h2);
        chk("R3 rx w1c", reg_rdata_o, 32'h0);
        step(0, 1, 0, 0, 32'h0);
        chk("R5 next packet taken", reg_rdata_o, 32'h2);
        step(0, 0, 1, 0, 32'h2);

        // R6..R8: test bit
        step(0, 0, 1, 0, 32'h8000_0000);
        chk("R6 test flag", reg_rdata_o, 32'h8000_0000);
        chk("R6 test irq", {31'd0, irq_o}, 32'h1);
        step(0, 0, 0, 1, 32'h0);
        chk("R7 read clears flag", reg_rdata_o, 32'h0);
        chk("R7 irq remains", {31'd0, irq_o}, 32'h1);
        step(0, 0, 1, 0, 32'h0000_0004);
        chk("R8 nonzero write keeps irq", {31'd0, irq_o}, 32'h1);
        chk("R10 reserved ignored", reg_rdata_o, 32'h0);
        step(0, 0, 1, 0, 32'h0);
        chk("R8 zero write retires", {31'd0, irq_o}, 32'h0);
        step(0, 0, 1, 0, 32'hFFFF_FFFC);
        chk("R10 reserved read 0", reg_rdata_o, 32'h8000_0000);
        step(0, 0, 1, 1, 32'h8000_0000);
        chk("R7 write beats read", reg_rdata_o, 32'h8000_0000);
        step(0, 0, 1, 1, 32'h0);
        chk("R8 all clear", {31'd0, irq_o}, 32'h0);

        // R9: pseudo-random mix against the model
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0], lfsr[1], lfsr[2] & lfsr[3], lfsr[4] & lfsr[5],
                 lfsr[6] ? 32'h0 : {lfsr[7], 28'd0, lfsr[10:8]});
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule